// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block holds a single exclusive reservation on behalf of one agent so that a paired load-exclusive and store-exclusive can form an atomic read-modify-write. A load-exclusive records the doubleword (aligned 8-byte granule) it touched. A later store-exclusive to that granule is granted only if no other agent has written any byte of the granule since the load. On a grant, the block forwards the write to memory. On a refusal, memory is left untouched. Either way, the block returns a status word for the agent's status register: 0 when the write was granted and 1 when it was refused.

Writes by other agents reach the block on a snoop port. Each snoop carries an address and a naturally aligned size, given as log2 of the byte count. The block does not stall a load-exclusive and does not stall a snoop. The store-exclusive request and the memory write each use a valid/ready pair.

Back-pressure rules:
- A store-exclusive is accepted on a cycle where `st_valid` and `st_ready` are both high.
- `st_ready` is low while a granted write is waiting for `mem_wr_ready`.
- Once `mem_wr_valid` is high, the write address and data hold until the cycle where `mem_wr_ready` is high.

Top module: `excl_monitor`

## Requirements
- R1: After reset there is no reservation, `resp_valid` and `mem_wr_valid` are 0, and `st_ready` is 1.
- R2: A load-exclusive sets a reservation on the 8-byte granule holding `ld_addr`; address bits [2:0] are ignored, and a new load replaces any older reservation.
- R3: A store-exclusive accepted while the reservation is intact and its address lies in the reserved granule returns status 0 and raises `mem_wr_valid` with its own address and data in the cycle after acceptance.
- R4: A refused store-exclusive returns status 1 and raises no memory write.
- R5: A store-exclusive whose address lies in a different 8-byte granule from the reservation is refused.
- R6: Every accepted store-exclusive clears the reservation, whether it is granted or refused, so a second store with no new load is refused.
- R7: A snoop of size 2^k bytes (k in `snp_size`, values above 6 treated as 6), aligned to max(2^k, 8), that overlaps the reserved granule clears the reservation; a snoop that does not overlap leaves it intact.
- R8: A store-exclusive is judged against the reservation as it stood before the cycle, and a snoop hit in the same cycle refuses it. A load-exclusive in the same cycle as a store or snoop leaves its own new reservation in place.
- R9: A store-exclusive issued before any load-exclusive is refused.
- R10: `st_ready` is low while a granted write waits. `mem_wr_addr` and `mem_wr_data` hold steady until `mem_wr_ready` is seen.
- R11: `resp_valid` pulses for exactly one cycle, one cycle after each accepted store. `resp_status` is STAT_W bits wide with value 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load-exclusive issued this cycle |
| ld_addr | input | ADDR_W | Load-exclusive byte address |
| st_valid | input | 1 | Store-exclusive request valid |
| st_ready | output | 1 | Store-exclusive request can be taken |
| st_addr | input | ADDR_W | Store-exclusive byte address |
| st_data | input | DATA_W | Store-exclusive data |
| snp_valid | input | 1 | Write by another agent seen this cycle |
| snp_addr | input | ADDR_W | Snooped write address |
| snp_size | input | 3 | log2 of snooped write size in bytes |
| mem_wr_valid | output | 1 | Granted write to memory valid |
| mem_wr_ready | input | 1 | Memory takes the write |
| mem_wr_addr | output | ADDR_W | Granted write address |
| mem_wr_data | output | DATA_W | Granted write data |
| resp_valid | output | 1 | Status word valid |
| resp_status | output | STAT_W | 0 on grant, 1 on refusal |

## Verification
The bench builds the monitor with a 12-bit address, 16-bit data and a 4-bit status word. The narrow address lets random traffic, confined to a handful of neighbouring granules, produce frequent reservation hits, near misses one granule away, and snoops of every size that straddle the reserved granule. Holding `mem_wr_ready` low for runs of cycles brings the store back-pressure and write-hold rules within reach. Same-cycle collisions of load, store and snoop occur both in directed steps and in random traffic.

// File: rtl/excl_pkg.sv
package excl_pkg;
  // status word codes returned to the agent
  typedef enum logic {
    XS_OK   = 1'b0,
    XS_FAIL = 1'b1
  } xstat_e;

  // byte-size log2 of one reservation granule (doubleword)
  localparam int unsigned GRAN_LOG2 = 3;
  // largest snoop size log2 honoured; bigger codes are clamped
  localparam int unsigned SNP_MAX_LOG2 = 6;
endpackage

// File: rtl/excl_gran_match.sv
module excl_gran_match #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GRAN_L2  = 3,
  parameter int unsigned MAX_L2   = 6,
  parameter int unsigned SZ_W     = 3
) (
  input  logic [ADDR_W-1:0] a,
  input  logic [ADDR_W-1:0] b,
  input  logic [SZ_W-1:0]   size_l2,
  output logic              hit
);
  logic [ADDR_W-1:0] care;
  int                eff;

  always_comb begin
    eff = int'(size_l2);
    if (eff > int'(MAX_L2)) eff = int'(MAX_L2);
    for (int i = 0; i < int'(ADDR_W); i++) begin
      care[i] = (i >= int'(GRAN_L2)) && (i >= eff);
    end
    hit = (((a ^ b) & care) == '0);
  end
endmodule

// File: rtl/excl_resv.sv
module excl_resv #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned GRAN_L2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_set,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_clr,
  input  logic              snp_clr,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << GRAN_L2) - 64'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
    end else if (ld_set) begin
      resv_valid <= 1'b1;
      resv_addr  <= ld_addr & ~LOW_MASK;
    end else if (st_clr || snp_clr) begin
      resv_valid <= 1'b0;
    end
  end

  p_ld_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_set |=> resv_valid);
  p_st_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr && !ld_set) |=> !resv_valid);
  p_snoop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_clr && !ld_set) |=> !resv_valid);
  p_idle_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_set && !st_clr && !snp_clr) |=> $stable(resv_valid));
endmodule

// File: rtl/excl_wslot.sv
module excl_wslot #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_no_clobber_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [2:0]        snp_size,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              resp_valid,
  output logic [STAT_W-1:0] resp_status
);
  logic              resv_valid;
  logic [ADDR_W-1:0] resv_addr;
  logic              st_in_gran;
  logic              snp_in_gran;
  logic              snp_hit;
  logic              st_fire;
  logic              grant;
  xstat_e            verdict;

  excl_gran_match #(
    .ADDR_W (ADDR_W), .GRAN_L2(GRAN_LOG2), .MAX_L2(SNP_MAX_LOG2), .SZ_W(3)
  ) u_st_cmp (
    .a(st_addr), .b(resv_addr), .size_l2(3'd0), .hit(st_in_gran)
  );

  excl_gran_match #(
    .ADDR_W (ADDR_W), .GRAN_L2(GRAN_LOG2), .MAX_L2(SNP_MAX_LOG2), .SZ_W(3)
  ) u_snp_cmp (
    .a(snp_addr), .b(resv_addr), .size_l2(snp_size), .hit(snp_in_gran)
  );

  assign snp_hit = snp_valid && resv_valid && snp_in_gran;
  assign st_fire = st_valid && st_ready;
  assign grant   = st_fire && resv_valid && st_in_gran && !snp_hit;
  assign verdict = grant ? XS_OK : XS_FAIL;

  excl_resv #(.ADDR_W(ADDR_W), .GRAN_L2(GRAN_LOG2)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .ld_set(ld_valid), .ld_addr(ld_addr),
    .st_clr(st_fire), .snp_clr(snp_hit),
    .resv_valid(resv_valid), .resv_addr(resv_addr)
  );

  excl_wslot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wslot (
    .clk(clk), .rst_n(rst_n),
    .load(grant), .in_addr(st_addr), .in_data(st_data),
    .out_ready(mem_wr_ready), .out_valid(mem_wr_valid),
    .out_addr(mem_wr_addr), .out_data(mem_wr_data)
  );

  assign st_ready = !mem_wr_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_status <= '0;
    end else begin
      resp_valid  <= st_fire;
      resp_status <= st_fire ? STAT_W'(verdict) : '0;
    end
  end

  p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire |=> resp_valid);
  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !st_fire |=> !resp_valid);
  p_ok_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == '0) |-> mem_wr_valid);
  p_fail_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status != '0) |-> !mem_wr_valid);
  p_no_resv_fails_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && !resv_valid) |=> (resp_status != '0));
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> !st_ready);
endmodule

// File: tb/sim_excl_monitor.sv
module sim_excl_monitor;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 0, st_valid = 0, snp_valid = 0, mem_wr_ready = 0;
  logic [AW-1:0] ld_addr = '0, st_addr = '0, snp_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [2:0] snp_size = '0;
  logic st_ready, mem_wr_valid, resp_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic [SW-1:0] resp_status;

  always #10 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .DATA_W(DW), .STAT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_size(snp_size),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .resp_valid(resp_valid), .resp_status(resp_status)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit m_rv = 0; int m_raddr = 0;
  string m_why = "R9";
  bit m_wv = 0; int m_waddr = 0; int m_wdata = 0;
  bit m_pv = 0; int m_ps = 0; string m_ptag = "R11";
  bit m_hold = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit snoop_hits(input int ra, input int sa, input int sz);
    int sh;
    sh = (sz > 6) ? 6 : sz;
    if (sh < 3) sh = 3;
    return (sa >> sh) == (ra >> sh);
  endfunction

  task automatic cyc(input bit ld, input int la, input bit st, input int sa, input int sd,
                     input bit sn, input int na, input int nsz, input bit rdy);
    bit fire, hit, pass, n_rv, n_wv;
    int n_raddr;
    string why, n_why;
    @(negedge clk);
    // compare outputs produced by the last edge
    chk(st_ready == !m_wv, "R10 st_ready", int'(st_ready), int'(!m_wv));
    chk(resp_valid == m_pv, "R11 resp_valid", int'(resp_valid), int'(m_pv));
    if (m_pv) chk(int'(resp_status) == m_ps, m_ptag, int'(resp_status), m_ps);
    chk(mem_wr_valid == m_wv, m_pv ? m_ptag : "R10 mem_wr_valid", int'(mem_wr_valid), int'(m_wv));
    if (m_wv) begin
      chk(int'(mem_wr_addr) == m_waddr, m_hold ? "R10 addr hold" : "R3 addr", int'(mem_wr_addr), m_waddr);
      chk(int'(mem_wr_data) == m_wdata, m_hold ? "R10 data hold" : "R3 data", int'(mem_wr_data), m_wdata);
    end
    ld_valid = ld; ld_addr = AW'(la);
    st_valid = st; st_addr = AW'(sa); st_data = DW'(sd);
    snp_valid = sn; snp_addr = AW'(na); snp_size = 3'(nsz);
    mem_wr_ready = rdy;
    // model next state
    fire = st && !m_wv;
    hit = sn && m_rv && snoop_hits(m_raddr, na & ((1 << AW) - 1), nsz);
    pass = 0; why = m_why;
    if (fire) begin
      if (!m_rv) why = m_why;
      else if ((sa >> 3) != (m_raddr >> 3)) why = "R5";
      else if (hit) why = "R8";
      else begin pass = 1; why = "R3 R2"; end
    end
    n_rv = m_rv; n_raddr = m_raddr; n_why = m_why;
    if (ld) begin n_rv = 1; n_raddr = la & ~7; n_why = "R2"; end
    else if (fire) begin n_rv = 0; n_why = "R6"; end
    else if (hit) begin n_rv = 0; n_why = "R7"; end
    n_wv = fire ? pass : (m_wv && !rdy);
    m_hold = m_wv && !rdy;
    @(posedge clk);
    m_rv = n_rv; m_raddr = n_raddr; m_why = n_why;
    if (fire && pass) begin m_waddr = sa; m_wdata = sd; end
    m_wv = n_wv;
    m_pv = fire; m_ps = pass ? 0 : 1;
    m_ptag = pass ? "R3" : (why == "R3 R2" ? "R4" : why);
    if (fire && !pass) m_ptag = {why, " R4"};
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(st_ready == 1'b1, "R1 st_ready", int'(st_ready), 1);
    chk(mem_wr_valid == 1'b0, "R1 mem_wr_valid", int'(mem_wr_valid), 0);
    chk(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
    // R9: store before any load
    cyc(0, 0, 1, 'h100, 'h1111, 0, 0, 0, 1);
    // R2/R3: load then store, same granule other byte
    cyc(1, 'h105, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 1, 'h102, 'h2222, 0, 0, 0, 1);
    // R6: second store with no new load
    cyc(0, 0, 1, 'h100, 'h3333, 0, 0, 0, 1);
    // R7: non-overlapping snoop keeps, then overlapping 16-byte snoop clears
    cyc(1, 'h100, 0, 0, 0, 1, 'h108, 0, 1);
    cyc(0, 0, 1, 'h100, 'h4444, 0, 0, 0, 1);
    cyc(1, 'h100, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 'h108, 4, 1);
    cyc(0, 0, 1, 'h100, 'h5555, 0, 0, 0, 1);
    // R5: neighbour granule
    cyc(1, 'h100, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 1, 'h108, 'h6666, 0, 0, 0, 1);
    // R8: snoop hit in store cycle, load in same cycle as store
    cyc(1, 'h120, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 1, 'h120, 'h7777, 1, 'h124, 0, 1);
    cyc(1, 'h140, 0, 0, 0, 0, 0, 0, 1);
    cyc(1, 'h140, 1, 'h140, 'h8888, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 1, 'h140, 'h9999, 0, 0, 0, 1);
    // R10: granted write held under back-pressure
    cyc(1, 'h160, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 'h160, 'hAAAA, 0, 0, 0, 0);
    cyc(1, 'h160, 1, 'h160, 'hBBBB, 0, 0, 0, 0);
    cyc(0, 0, 1, 'h160, 'hCCCC, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 1, 'h160, 'hDDDD, 0, 0, 0, 1);
    // random traffic over a few granules
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 5) == 0, 'h200 + int'($urandom % 32),
          ($urandom % 3) == 0, 'h200 + int'($urandom % 32), int'($urandom % 65536),
          ($urandom % 4) == 0, 'h1C0 + int'($urandom % 128), int'($urandom % 8),
          ($urandom % 5) < 3);
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule